// File: doc/BRIEF.md
# Fractional-Rate PWM Generator with Deferred Update

This block drives one pulse-width-modulated output from a fixed clock. A phase accumulator of `BU_W` bits adds a programmable base-unit increment on every clock. Each time it overflows, a new output cycle starts, so the output frequency is `base_unit * f_clk / 2^BU_W`. An 8-bit on-time divisor is compared against the top byte of the accumulator to set the duty cycle. A larger divisor gives a shorter high time.

Software uses one 32-bit control word through a write strobe and a combinational read port. The base-unit and divisor fields land in a shadow copy. They reach the active datapath only when the next output cycle starts, and only if software has raised the self-clearing update-request flag. The flag reads back as pending until the copy happens, so software can poll it before it writes again. The enable bit acts at once, which lets software use either ordering: enable before the update lands, or enable after the flag has cleared.

Top module: `frac_pwm`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `rd_data` reads 0 and `pwm_out` is low.
- R2: Control word layout: bit 31 is enable, bit 30 is update-request/pending, bits `[8+BU_W-1:8]` are the base unit and bits `[7:0]` are the divisor. A read returns enable, pending and the shadow fields. Bits 29 down to `8+BU_W` are ignored on write and read as 0.
- R3: With a base unit `bu` that divides `2^BU_W`, the output repeats every `2^BU_W / bu` clocks.
- R4: The output is high while the top 8 accumulator bits are greater than or equal to the divisor. In each period the high time is the number of accumulator steps whose top byte reaches the divisor. A divisor of 0 holds the output constantly high.
- R5: A write with bit 30 set raises pending, and bit 30 reads 1 from the next cycle. A later write with bit 30 clear does not drop it. Only the hardware clears it.
- R6: While the output is running, new field values take effect only at the next accumulator wrap. The current cycle finishes with the old settings. Pending clears in the same clock as the copy.
- R7: While enable is clear, or the active base unit is 0, a pending request is copied on the next clock.
- R8: While enable is clear, the output is low, the accumulator is held at 0 and the register fields are retained. After re-enabling, the first cycle starts from accumulator 0.
- R9: With enable set and an active base unit of 0, the output stays low.
- R10: A single write that sets both enable and the request while the old settings are running produces the new period and duty after the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback: enable, pending, shadow fields |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures period and high time across base units from 256 to 4096 and divisors from 1 to 200. A wrong carry or comparison shows up there as an off-by-one in either count. For the deferred update, the bench changes the base unit in the middle of a cycle and counts the remaining high samples. A design that applied the change at once would end that pulse early, and a design that never committed would keep the old period afterwards. The bench also covers:
- re-enabling after a disable, where the first rising edge must come exactly 128 samples later; stale accumulator state would shift that edge;
- a divisor of 0, which must give constant high, and a base unit of 0, which must give constant low;
- the combined enable-plus-request write;
- whether pending survives a plain rewrite.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;
    localparam int CTL_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int REQ_BIT = 30;
    localparam int BU_LSB  = 8;
    localparam int DIV_W   = 8;

    typedef struct packed {
        logic en;
        logic req;
    } ctl_flags_t;

    function automatic ctl_flags_t get_flags(input logic [CTL_W-1:0] word);
        ctl_flags_t f;
        f.en  = word[EN_BIT];
        f.req = word[REQ_BIT];
        return f;
    endfunction
endpackage

// File: rtl/frac_pwm_regs.sv
module frac_pwm_regs
    import frac_pwm_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CTL_W-1:0]    wr_data,
    input  logic                commit,
    output logic                en_q,
    output logic                pend_q,
    output logic [BU_W-1:0]     sh_bu,
    output logic [DIV_W-1:0]    sh_div,
    output logic [CTL_W-1:0]    rd_data
);
    localparam int TOP_USED = BU_LSB + BU_W;

    ctl_flags_t wf;
    assign wf = get_flags(wr_data);

    generate
        if (TOP_USED < REQ_BIT) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^wr_data[REQ_BIT-1:TOP_USED];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            sh_bu  <= '0;
            sh_div <= '0;
        end else begin
            if (wr_en) begin
                en_q   <= wf.en;
                sh_bu  <= wr_data[BU_LSB +: BU_W];
                sh_div <= wr_data[DIV_W-1:0];
            end
            if (wr_en && wf.req)
                pend_q <= 1'b1;
            else if (commit)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data                 = '0;
        rd_data[EN_BIT]         = en_q;
        rd_data[REQ_BIT]        = pend_q;
        rd_data[BU_LSB +: BU_W] = sh_bu;
        rd_data[DIV_W-1:0]      = sh_div;
    end
endmodule

// File: rtl/frac_pwm_accum.sv
module frac_pwm_accum
    import frac_pwm_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pend,
    input  logic [BU_W-1:0]   sh_bu,
    input  logic [DIV_W-1:0]  sh_div,
    output logic [BU_W-1:0]   act_bu,
    output logic [DIV_W-1:0]  act_div,
    output logic [DIV_W-1:0]  acc_top,
    output logic              running,
    output logic              commit
);
    logic [BU_W-1:0] acc;
    logic [BU_W:0]   sum;
    logic            cyc_start;

    always_comb begin
        sum       = {1'b0, acc} + {1'b0, act_bu};
        running   = en && (act_bu != '0);
        cyc_start = running ? sum[BU_W] : 1'b1;
        commit    = cyc_start && pend;
    end

    assign acc_top = acc[BU_W-1 -: DIV_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            act_bu  <= '0;
            act_div <= '0;
        end else begin
            acc <= en ? sum[BU_W-1:0] : '0;
            if (commit) begin
                act_bu  <= sh_bu;
                act_div <= sh_div;
            end
        end
    end
endmodule

// File: rtl/frac_pwm_duty.sv
module frac_pwm_duty
    import frac_pwm_pkg::*;
(
    input  logic             running,
    input  logic [DIV_W-1:0] acc_top,
    input  logic [DIV_W-1:0] act_div,
    output logic             pwm_out
);
    assign pwm_out = running && (acc_top >= act_div);
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
    import frac_pwm_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    logic             en_q, pend_q, running, commit;
    logic [BU_W-1:0]  sh_bu, act_bu;
    logic [DIV_W-1:0] sh_div, act_div, acc_top;

    frac_pwm_regs #(.BU_W(BU_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .commit(commit), .en_q(en_q), .pend_q(pend_q),
        .sh_bu(sh_bu), .sh_div(sh_div), .rd_data(rd_data)
    );

    frac_pwm_accum #(.BU_W(BU_W)) u_accum (
        .clk(clk), .rst(rst), .en(en_q), .pend(pend_q),
        .sh_bu(sh_bu), .sh_div(sh_div), .act_bu(act_bu), .act_div(act_div),
        .acc_top(acc_top), .running(running), .commit(commit)
    );

    frac_pwm_duty u_duty (
        .running(running), .acc_top(acc_top), .act_div(act_div),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/frac_pwm_chk.sv
module frac_pwm_chk #(
    parameter int BU_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_req,
    input logic            rd_req,
    input logic            pwm_out,
    input logic            en,
    input logic            pend,
    input logic            running,
    input logic            commit,
    input logic [BU_W-1:0] act_bu,
    input logic [7:0]      act_div,
    input logic [7:0]      acc_top
);
    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_out);

    p_acc_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc_top == 8'd0));

    p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(act_bu) && $stable(act_div)));

    p_req_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (commit && !wr_req) |=> !pend);

    p_req_visible_r5: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> rd_req);

    p_idle_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && !en) |-> commit);

    p_zero_bu_low_r9: assert property (@(posedge clk) disable iff (rst)
        (en && act_bu == '0) |-> !pwm_out);

    p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (running && act_div == 8'd0) |-> pwm_out);
endmodule

bind frac_pwm frac_pwm_chk #(.BU_W(BU_W)) u_chk (
    .clk(clk), .rst(rst),
    .wr_req(wr_en && wr_data[30]), .rd_req(rd_data[30]),
    .pwm_out(pwm_out), .en(en_q), .pend(pend_q), .running(running),
    .commit(commit), .act_bu(act_bu), .act_div(act_div), .acc_top(acc_top)
);

// File: tb/frac_pwm_tb.sv
`timescale 1ns/1ps
module frac_pwm_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    frac_pwm #(.BU_W(16)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [15:0] bu;
        logic [7:0]  dv;
        int          per;
        int          hi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd256,  8'd128, 256, 128},
        '{16'd256,  8'd64,  256, 192},
        '{16'd1024, 8'd100, 64,  39},
        '{16'd2048, 8'd8,   32,  31},
        '{16'd4096, 8'd200, 16,  3},
        '{16'd512,  8'd1,   128, 127}
    };

    function automatic logic [31:0] mk(input logic en, input logic rq,
                                       input logic [15:0] bu, input logic [7:0] dv);
        return {en, rq, 6'b0, bu, dv};
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic measure(output int per, output int hi);
        logic prev;
        int   guard;
        prev  = pwm_out;
        guard = 0;
        per   = 0;
        hi    = 0;
        while (!(prev == 1'b0 && pwm_out == 1'b1) && guard < 5000) begin
            prev = pwm_out;
            @(negedge clk);
            guard++;
        end
        per = 1;
        hi  = 1;
        prev = pwm_out;
        @(negedge clk);
        while (!(prev == 1'b0 && pwm_out == 1'b1) && per < 5000) begin
            per++;
            if (pwm_out) hi++;
            prev = pwm_out;
            @(negedge clk);
        end
    endtask

    task automatic count_level(input logic lvl, input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out == lvl) seen++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int per, hi, cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pwm_out", pwm_out, 0);

        // R2: spare bits ignored, layout of readback; R5 pending visible
        wr(32'h7F00_1234);
        chk("R2/R5 readback pending", rd_data, 32'h4000_1234);
        @(negedge clk);
        // R7: idle commit clears pending next clock
        chk("R7 idle commit", rd_data, 32'h0000_1234);

        // R3, R4: vector table
        foreach (VECS[i]) begin
            wr(mk(1'b0, 1'b1, VECS[i].bu, VECS[i].dv));
            @(negedge clk);
            chk("R7 cleared", rd_data, mk(1'b0, 1'b0, VECS[i].bu, VECS[i].dv));
            wr(mk(1'b1, 1'b0, VECS[i].bu, VECS[i].dv));
            for (int r = 0; r < 2; r++) begin
                measure(per, hi);
                chk("R3 period", per, VECS[i].per);
                chk("R4 high", hi, VECS[i].hi);
            end
        end

        // R4: divisor 0 gives constant high
        wr(mk(1'b0, 1'b1, 16'd256, 8'd0));
        @(negedge clk);
        wr(mk(1'b1, 1'b0, 16'd256, 8'd0));
        count_level(1'b1, 600, cnt);
        chk("R4 full duty", cnt, 600);

        // R8: disable holds low, keeps fields, restarts from zero
        wr(mk(1'b0, 1'b1, 16'd256, 8'd128));
        @(negedge clk);
        count_level(1'b0, 300, cnt);
        chk("R8 low when off", cnt, 300);
        chk("R8 retained", rd_data, mk(1'b0, 1'b0, 16'd256, 8'd128));
        wr(mk(1'b1, 1'b0, 16'd256, 8'd128));
        cnt = 0;
        while (pwm_out == 1'b0 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R8 restart from zero", cnt, 128);

        // R6: mid-cycle change deferred to wrap
        measure(per, hi);
        repeat (10) @(negedge clk);
        wr(mk(1'b1, 1'b1, 16'd512, 8'd32));
        chk("R5 pending set", rd_data[30], 1);
        wr(mk(1'b1, 1'b0, 16'd512, 8'd32));
        chk("R5 pending kept", rd_data[30], 1);
        cnt = 0;
        while (pwm_out == 1'b1 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R6 old cycle completes", cnt, 114);
        chk("R6 pending clears at wrap", rd_data[30], 0);
        measure(per, hi);
        chk("R6 new period", per, 128);
        chk("R6 new high", hi, 112);

        // R9: base unit 0 stops output
        wr(mk(1'b1, 1'b1, 16'd0, 8'd0));
        cnt = 0;
        while (rd_data[30] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R9 request taken", rd_data[30], 0);
        count_level(1'b0, 300, cnt);
        chk("R9 low with bu 0", cnt, 300);

        // R10: enable and request in one write over running old settings
        wr(mk(1'b0, 1'b1, 16'd256, 8'd128));
        @(negedge clk);
        wr(mk(1'b1, 1'b1, 16'd1024, 8'd100));
        cnt = 0;
        while (rd_data[30] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R10 commit after wrap", (cnt > 200 && cnt < 300) ? 1 : 0, 1);
        measure(per, hi);
        chk("R10 period", per, 64);
        chk("R10 high", hi, 39);

        // R1: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rd_data", rd_data, 0);
        chk("R1 reset pwm_out", pwm_out, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule